// File: doc/BRIEF.md
# I2C Slave Event Status Register

This block keeps the sticky event flags of an I2C slave peripheral and turns them into one interrupt line. The bit-level protocol engine sends single-cycle pulses for each event it sees. These include a transfer start, a completed byte, a bus-free request, an output mismatch, an asynchronous address match, a NAK and a STOP. The engine also drives a level that gives the transfer direction. The block latches these pulses into a 16-bit status word that software reads over a simple register port.

Software clears each flag on its own by writing 1 to that flag's bit. A summary bit reads as 1 while any flag is set. The interrupt output is the registered AND of the summary bit and an enable input.

The shared bit 5 reports a data hazard, and its meaning depends on direction. When transmitting, it marks a start with no fresh transmit data. When receiving, it marks a received byte that overwrote one software had not yet read. Both hazards are tracked only while clock stretching is off. The block follows the data-register accesses on the same port to know whether data is fresh.

Top module: `i2c_slave_status`

## Requirements
- R1: After reset every flag, both internal data markers and `irq` are 0, and a status read returns 16'h0000.
- R2: Status bits 15 to 8 and bit 6 always read as 0.
- R3: Status bit 7 reads as 1 exactly when at least one of bits 5 to 0 is 1. Bit 7 returns to 0 only once all six are 0.
- R4: Writing to the status address clears each of bits 5 to 0 whose write-data bit is 1. Bits written with 0 keep their value, and writes to bit 7 have no effect.
- R5: When an event sets a flag in the same cycle that a write-1 clears it, the flag ends up set.
- R6: An event pulse sets its flag at the next clock edge. The mapping is bus-free request to bit 4, output mismatch to bit 3, asynchronous address detect to bit 2, NAK to bit 1 and STOP to bit 0.
- R7: A transfer start with `dirRx`=0 and `stretchEn`=0, while no transmit data is loaded, sets bit 5 (underflow). With `stretchEn`=1 it sets nothing.
- R8: A write to the transmit data address marks transmit data as loaded, and a transfer start consumes that mark. A start that finds the data loaded does not set bit 5.
- R9: A completed byte marks receive data as unread, and a read of the receive data address removes that mark. A completed byte with `dirRx`=1 and `stretchEn`=0 that arrives while the mark is set sets bit 5 (overflow).
- R10: `irq` equals the value of (`irqEn` AND status bit 7) from one cycle earlier. It therefore falls in the cycle after the last flag is cleared.
- R11: Bit 5 is set only by the hazard that belongs to the current direction. A transfer start while `dirRx`=1, or a completed byte while `dirRx`=0, leaves bit 5 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register word address (status, transmit data, receive data) |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 16 | Read data; status word when reading the status address, else 0 |
| dirRx | input | 1 | Transfer direction: 1 receive, 0 transmit |
| stretchEn | input | 1 | Clock stretching enabled; suppresses bit 5 hazards |
| irqEn | input | 1 | Interrupt enable |
| evTxStart | input | 1 | Pulse: a byte transmission begins |
| evRxDone | input | 1 | Pulse: a byte has been received |
| evBusFree | input | 1 | Pulse: bus-free request accepted |
| evMismatch | input | 1 | Pulse: output data mismatch |
| evAddrAsync | input | 1 | Pulse: asynchronous address detected |
| evNak | input | 1 | Pulse: NAK received |
| evStop | input | 1 | Pulse: STOP detected |
| irq | output | 1 | Registered interrupt request |

## Verification
The overflow case is the hardest state to reach from the ports. It needs an unread mark set by an earlier byte and then a second byte in receive direction with stretching off. The stimulus therefore sends two completed bytes back to back and expects the flag only on the second. It then clears the mark with a receive-data read and shows that the same sequence no longer raises the flag. The set-versus-clear collision is forced by driving an event pulse in the same cycle as a write-1 to that bit. The one-cycle interrupt lag is sampled on both the rising and the falling side.

// File: rtl/i2c_slave_status_pkg.sv
package i2c_slave_status_pkg;

  localparam int DATA_W    = 16;
  localparam int NUM_FLAGS = 6;

  // bit positions of the status word (software decodes these)
  localparam int BIT_STOP    = 0;
  localparam int BIT_NAK     = 1;
  localparam int BIT_ADDRASY = 2;
  localparam int BIT_MISMTCH = 3;
  localparam int BIT_BUSFREE = 4;
  localparam int BIT_HAZARD  = 5;
  localparam int BIT_SUMMARY = 7;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setMask;
    logic [NUM_FLAGS-1:0] clrMask;
    logic                 statRd;
  } flagStrobes_t;

endpackage

// File: rtl/i2c_slave_status_ctrl.sv
module i2c_slave_status_ctrl
  import i2c_slave_status_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int TX_ADDR   = 1,
  parameter int RX_ADDR   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regRdEn,
  input  logic                dirRx,
  input  logic                stretchEn,
  input  logic                evTxStart,
  input  logic                evRxDone,
  input  logic                evBusFree,
  input  logic                evMismatch,
  input  logic                evAddrAsync,
  input  logic                evNak,
  input  logic                evStop,
  output flagStrobes_t        strobes,
  output logic                txLoaded,
  output logic                rxUnread
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] TX_A   = ADDR_W'(TX_ADDR);
  localparam logic [ADDR_W-1:0] RX_A   = ADDR_W'(RX_ADDR);

  logic statHit, txHit, rxHit;
  logic statWr, txWr, rxRd;
  logic txUnderflow, rxOverflow;
  logic txLoadedQ, rxUnreadQ;

  assign statHit = (regAddr == STAT_A);
  assign txHit   = (regAddr == TX_A);
  assign rxHit   = (regAddr == RX_A);

  assign statWr  = regWrEn & statHit;
  assign txWr    = regWrEn & txHit;
  assign rxRd    = regRdEn & rxHit;

  // transmit data freshness: a write loads, a start consumes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txLoadedQ <= 1'b0;
    else if (txWr)      txLoadedQ <= 1'b1;
    else if (evTxStart) txLoadedQ <= 1'b0;
  end

  // receive data freshness: a new byte marks, a read unmarks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxUnreadQ <= 1'b0;
    else if (evRxDone) rxUnreadQ <= 1'b1;
    else if (rxRd)     rxUnreadQ <= 1'b0;
  end

  assign txUnderflow = evTxStart & ~dirRx & ~stretchEn & ~txLoadedQ;
  assign rxOverflow  = evRxDone  &  dirRx & ~stretchEn &  rxUnreadQ;

  always_comb begin
    strobes = '0;
    strobes.setMask[BIT_HAZARD]  = txUnderflow | rxOverflow;
    strobes.setMask[BIT_BUSFREE] = evBusFree;
    strobes.setMask[BIT_MISMTCH] = evMismatch;
    strobes.setMask[BIT_ADDRASY] = evAddrAsync;
    strobes.setMask[BIT_NAK]     = evNak;
    strobes.setMask[BIT_STOP]    = evStop;
    strobes.clrMask = statWr ? regWrData[NUM_FLAGS-1:0] : '0;
    strobes.statRd  = regRdEn & statHit;
  end

  assign txLoaded = txLoadedQ;
  assign rxUnread = rxUnreadQ;

endmodule

// File: rtl/i2c_slave_status_dp.sv
module i2c_slave_status_dp
  import i2c_slave_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  flagStrobes_t          strobes,
  input  logic                  irqEn,
  output logic [NUM_FLAGS-1:0]  flagQ,
  output logic                  summary,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irq
);

  localparam int RSVD_LO = NUM_FLAGS;
  localparam int RSVD_HI = DATA_W - 1;

  logic irqQ;

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ[i] <= 1'b0;
        else       flagQ[i] <= strobes.setMask[i] | (flagQ[i] & ~strobes.clrMask[i]);
      end
    end
  endgenerate

  assign summary = |flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= irqEn & summary;
  end
  assign irq = irqQ;

  always_comb begin
    rdData = '0;
    if (strobes.statRd) begin
      for (int b = RSVD_LO; b <= RSVD_HI; b++) rdData[b] = 1'b0;
      rdData[NUM_FLAGS-1:0] = flagQ;
      rdData[BIT_SUMMARY]   = summary;
    end
  end

endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status
  import i2c_slave_status_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int TX_ADDR   = 1,
  parameter int RX_ADDR   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  input  logic              regRdEn,
  output logic [15:0]       regRdData,
  input  logic              dirRx,
  input  logic              stretchEn,
  input  logic              irqEn,
  input  logic              evTxStart,
  input  logic              evRxDone,
  input  logic              evBusFree,
  input  logic              evMismatch,
  input  logic              evAddrAsync,
  input  logic              evNak,
  input  logic              evStop,
  output logic              irq
);

  flagStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 summary;
  logic                 txLoaded, rxUnread;

  i2c_slave_status_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .dirRx(dirRx), .stretchEn(stretchEn),
    .evTxStart(evTxStart), .evRxDone(evRxDone), .evBusFree(evBusFree),
    .evMismatch(evMismatch), .evAddrAsync(evAddrAsync), .evNak(evNak), .evStop(evStop),
    .strobes(strobes), .txLoaded(txLoaded), .rxUnread(rxUnread)
  );

  i2c_slave_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqEn(irqEn),
    .flagQ(flagQ), .summary(summary), .rdData(regRdData), .irq(irq)
  );

endmodule

// File: rtl/i2c_slave_status_chk.sv
module i2c_slave_status_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [15:0]       regWrData,
  input logic              regRdEn,
  input logic [15:0]       regRdData,
  input logic              dirRx,
  input logic              stretchEn,
  input logic              irqEn,
  input logic              evTxStart,
  input logic              evStop,
  input logic [5:0]        flagQ,
  input logic              txLoaded,
  input logic              irq
);

  logic statWrite;
  assign statWrite = regWrEn && (regAddr == ADDR_W'(STAT_ADDR));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[15:8] == 8'h00) && !regRdData[6]);

  // R3
  summary_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(STAT_ADDR)) |-> (regRdData[7] == (|regRdData[5:0])));

  // R4
  clear_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && regWrData[0] && !evStop) |=> !flagQ[0]);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> flagQ[0]);

  // R7
  underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evTxStart && !dirRx && !stretchEn && !txLoaded) |=> flagQ[5]);

  // R10
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(irqEn && (|flagQ))));

endmodule

bind i2c_slave_status i2c_slave_status_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
  .dirRx(dirRx), .stretchEn(stretchEn), .irqEn(irqEn), .evTxStart(evTxStart),
  .evStop(evStop), .flagQ(flagQ), .txLoaded(txLoaded), .irq(irq)
);

// File: tb/tb_i2c_slave_status.sv
`timescale 1ns/1ps
module tb_i2c_slave_status;

  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_TX   = 4'd1;
  localparam logic [ADDR_W-1:0] A_RX   = 4'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic dirRx = 1'b0, stretchEn = 1'b0, irqEn = 1'b0;
  logic evTxStart = 0, evRxDone = 0, evBusFree = 0, evMismatch = 0;
  logic evAddrAsync = 0, evNak = 0, evStop = 0;
  logic irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  i2c_slave_status dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .dirRx(dirRx), .stretchEn(stretchEn), .irqEn(irqEn),
    .evTxStart(evTxStart), .evRxDone(evRxDone), .evBusFree(evBusFree),
    .evMismatch(evMismatch), .evAddrAsync(evAddrAsync), .evNak(evNak),
    .evStop(evStop), .irq(irq)
  );

  // evt order: {txStart, rxDone, busFree, mismatch, addrAsync, nak, stop}
  typedef struct packed {
    logic [6:0] evt;
    logic       rx;
    logic       stretch;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] expStat;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'h01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81}, // R6 stop
    '{7'h02, 1'b0, 1'b0, 1'b0, 8'h00, 8'h83}, // R6 nak
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'h82}, // R4 clear bit0
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h82}, // R4 write 0
    '{7'h0C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h8E}, // R6 addr+mismatch
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h80, 8'h8E}, // R4 bit7 write ignored
    '{7'h10, 1'b0, 1'b0, 1'b0, 8'h00, 8'h9E}, // R6 bus free
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h1E, 8'h00}, // R3 all clear
    '{7'h40, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA0}, // R7 underflow
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h20, 8'h00}, // R4 clear bit5
    '{7'h40, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00}, // R7 stretch blocks
    '{7'h20, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}, // R9 first byte
    '{7'h20, 1'b1, 1'b0, 1'b0, 8'h00, 8'hA0}, // R9 overflow
    '{7'h01, 1'b0, 1'b0, 1'b1, 8'h20, 8'h81}, // R4/R6 mixed
    '{7'h01, 1'b0, 1'b0, 1'b1, 8'h01, 8'h81}, // R5 set wins
    '{7'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'h00}  // R4 final clear
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given stimulus, applied at a falling edge
  task automatic step(input logic [6:0] evt, input logic rx, input logic st,
                      input logic wr, input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                      input logic rd);
    {evTxStart, evRxDone, evBusFree, evMismatch, evAddrAsync, evNak, evStop} = evt;
    dirRx = rx; stretchEn = st;
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd;
    @(posedge clk);
    @(negedge clk);
    {evTxStart, evRxDone, evBusFree, evMismatch, evAddrAsync, evNak, evStop} = '0;
    regWrEn = 1'b0; regRdEn = 1'b0; stretchEn = 1'b0;
  endtask

  task automatic readStat(output logic [15:0] v);
    regAddr = A_STAT; regRdEn = 1'b1;
    #1 v = regRdData;
    regRdEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] s;
    irqEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readStat(s);
    check("R1 status after reset", s, 16'h0000);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);

    // table walk: R2 reserved bits are part of every 16-bit compare
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].evt, VECS[i].rx, VECS[i].stretch, VECS[i].wr, A_STAT,
           {8'h00, VECS[i].wdata}, 1'b0);
      readStat(s);
      check($sformatf("R2/R3 vector %0d", i), s, {8'h00, VECS[i].expStat});
    end

    // R10 interrupt lag
    step(7'h01, 0, 0, 0, A_STAT, 16'h0, 0);
    check("R10 irq low one cycle after set", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R10 irq high", {15'd0, irq}, 16'd1);
    step(7'h00, 0, 0, 1, A_STAT, 16'h0001, 0);
    check("R10 irq still high after clear edge", {15'd0, irq}, 16'd1);
    @(negedge clk);
    check("R10 irq low after clear", {15'd0, irq}, 16'd0);
    irqEn = 1'b0;
    step(7'h02, 0, 0, 0, A_STAT, 16'h0, 0);
    @(negedge clk);
    check("R10 irq gated by enable", {15'd0, irq}, 16'd0);
    step(7'h00, 0, 0, 1, A_STAT, 16'h0002, 0);
    irqEn = 1'b1;

    // R8 loaded marker
    step(7'h00, 0, 0, 1, A_TX, 16'h00AA, 0);
    step(7'h40, 0, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R8 loaded start no underflow", s, 16'h0000);
    step(7'h40, 0, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R8 marker consumed then underflow", s, 16'h00A0);
    step(7'h00, 0, 0, 1, A_STAT, 16'h0020, 0);

    // R9 unread marker (still marked from the table)
    step(7'h00, 1, 0, 0, A_RX, 16'h0, 1);
    step(7'h20, 1, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R9 read cleared marker no overflow", s, 16'h0000);
    step(7'h20, 1, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R9 overflow on second byte", s, 16'h00A0);
    step(7'h00, 1, 0, 1, A_STAT, 16'h0020, 0);

    // R11 direction gating (rx marker is set)
    step(7'h20, 0, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R11 rx byte in transmit direction", s, 16'h0000);
    step(7'h40, 1, 0, 0, A_STAT, 16'h0, 0);
    readStat(s);
    check("R11 tx start in receive direction", s, 16'h0000);

    // R1 reset again clears flags
    step(7'h1F, 0, 0, 0, A_STAT, 16'h0, 0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readStat(s);
    check("R1 status after second reset", s, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule